// File: doc/BRIEF.md
# External Bus Access Splitter

This block sits between an internal master and an external memory port. It accepts one read or write request of 8, 16 or 32 bits at any byte address. It turns that request into the shortest legal sequence of external cycles for the configured space width, which is either 16 bits or 8 bits. For every external cycle it drives an address and places write data on the correct byte lanes in big-endian order: the most significant byte of the request goes to the lowest address. It also drives the active-low read, write and lane-select outputs. On reads it collects the returned bytes into one right-justified result.

The block is controlled by a four-state machine. IDLE waits for a request. An accepted request (IDLE→ADDR) latches the request and the configuration. ADDR presents the cycle address for one clock with every strobe inactive (ADDR→STRB). STRB holds the address and drives the strobes for one clock, and read data is captured at the end of that clock. STRB→ADDR moves to the next piece. STRB→FINISH follows the last piece. FINISH raises the completion pulse for one clock (FINISH→IDLE).

Two write-strobe schemes are supported. In per-lane mode, each lane has its own write strobe. In shared mode, one write strobe is combined with per-lane select lines. A page flag marks the follow-on cycles of a split multi-byte access when page accesses are enabled for that direction.

Top module: `ebus_splitter`

## Requirements
- R1: In 16-bit space a byte request (req_size 0) takes one cycle at the request address; an even address uses the upper lane (ext_dout/ext_din bits 15:8) and an odd address uses the lower lane (bits 7:0).
- R2: In 16-bit space a halfword request (req_size 1) at an even address takes one cycle on both lanes; the upper lane carries the byte at the even address, which is the most significant byte of the data.
- R3: In 16-bit space a halfword request at an odd address takes two byte cycles, at addresses A and A+1, in that order.
- R4: In 16-bit space a word request (req_size 2) at an even address takes two halfword cycles, at A and A+2; every halfword cycle has an even address.
- R5: In 16-bit space a word request at an odd address takes three cycles in this order: a byte cycle at A, a halfword cycle at A+1, and a byte cycle at A+3.
- R6: In 8-bit space (cfg_bus8=1) a request of n bytes takes n byte cycles, at A through A+n-1, all on the lower lane; ext_we_hi_n, ext_be_hi_n and ext_be_lo_n stay high.
- R7: Strobes in a cycle: ext_rd_n is low on read cycles. With cfg_single_strobe=0, writes pull ext_we_hi_n/ext_we_lo_n low for the lanes in use and ext_we_n stays high. With cfg_single_strobe=1, writes pull ext_we_n low, and in 16-bit space ext_be_hi_n/ext_be_lo_n are low for the lanes in use on reads and writes alike.
- R8: ext_page is high only on the second and later cycles of a 16- or 32-bit request, and only if cfg_page_wr (writes) or cfg_page_rd (reads) is set.
- R9: A request is accepted only while busy is low. A req_valid pulse while busy starts no cycles and changes nothing. done is a one-clock pulse, and with it rdata holds the read value right-justified, with unused upper bits zero. Sizes are encoded 0 for byte, 1 for halfword and 2 for word; the value 3 behaves as a byte.
- R10: Each external cycle is one clock of address setup followed by one clock with active strobes. With N cycles, done is high in the clock 2N+1 edges after the accepting edge.
- R11: After reset all strobes are high, ext_page, busy and done are low, and ext_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 32 | Write data, right-justified |
| cfg_bus8 | input | 1 | 1 = 8-bit external space, 0 = 16-bit |
| cfg_single_strobe | input | 1 | 1 = shared write strobe with lane selects |
| cfg_page_rd | input | 1 | Allow page flag on reads |
| cfg_page_wr | input | 1 | Allow page flag on writes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read data |
| ext_addr | output | ADDR_W | External cycle address |
| ext_dout | output | 16 | Write data on external lanes |
| ext_din | input | 16 | Read data from external lanes |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_we_n | output | 1 | Shared write strobe, active low |
| ext_we_hi_n | output | 1 | Upper-lane write strobe, active low |
| ext_we_lo_n | output | 1 | Lower-lane write strobe, active low |
| ext_be_hi_n | output | 1 | Upper-lane select, active low |
| ext_be_lo_n | output | 1 | Lower-lane select, active low |
| ext_page | output | 1 | Cycle may be a page access |

## Verification
Strobes are due in the 2nd, 4th, … 2N-th clock after the accepting edge. The done pulse, and the assembled rdata with it, is due exactly in the (2N+1)-th clock. The bench drives each request at a falling edge. It counts falling edges until done appears and compares that count with 2N+1, where N comes from its own model of the splitting rules. A monitor samples strobes, address, lane data and page flag at every falling edge, logs each active cycle and updates a byte-addressed memory model. After done, two idle clocks pass before the log length is compared, so that any stray cycle started by an ignored request is caught.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
    localparam int unsigned REQ_BYTES  = 4;
    localparam int unsigned REQ_W      = REQ_BYTES * 8;
    localparam int unsigned LANES      = 2;
    localparam int unsigned EXT_W      = LANES * 8;
    localparam int unsigned MAX_PIECES = 4;
    localparam int unsigned IDX_W      = $clog2(MAX_PIECES);
    localparam int unsigned CNT_W      = IDX_W + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_STRB   = 2'd2,
        ST_FINISH = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic [1:0] offs;
        logic       half;
    } piece_t;

    function automatic int unsigned size_bytes(input logic [1:0] sz);
        unique case (sz)
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/ebus_plan.sv
module ebus_plan
    import ebus_pkg::*;
(
    input  logic [1:0]       size,
    input  logic             addr_odd,
    input  logic             bus8,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] count,
    output piece_t           piece
);
    always_comb begin
        count      = CNT_W'(1);
        piece.offs = 2'd0;
        piece.half = 1'b0;
        if (bus8) begin
            count      = CNT_W'(size_bytes(size));
            piece.offs = idx;
        end else begin
            unique case (size)
                SZ_HALF: begin
                    if (!addr_odd) begin
                        piece.half = 1'b1;
                    end else begin
                        count      = CNT_W'(2);
                        piece.offs = idx;
                    end
                end
                SZ_WORD: begin
                    if (!addr_odd) begin
                        count      = CNT_W'(2);
                        piece.half = 1'b1;
                        piece.offs = {idx[0], 1'b0};
                    end else begin
                        count = CNT_W'(3);
                        unique case (idx)
                            2'd0:    piece.offs = 2'd0;
                            2'd1: begin
                                piece.offs = 2'd1;
                                piece.half = 1'b1;
                            end
                            default: piece.offs = 2'd3;
                        endcase
                    end
                end
                default: begin
                    count = CNT_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/ebus_lanes.sv
module ebus_lanes
    import ebus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             drive,
    input  logic             write,
    input  logic             bus8,
    input  logic             single_strobe,
    input  logic [1:0]       size,
    input  logic             cyc_addr0,
    input  piece_t           piece,
    input  logic [REQ_W-1:0] wdata,
    output logic [EXT_W-1:0] dout,
    output logic             hi_used,
    output logic             lo_used,
    output logic             rd_n,
    output logic             we_n,
    output logic             we_hi_n,
    output logic             we_lo_n,
    output logic             be_hi_n,
    output logic             be_lo_n
);
    function automatic logic [7:0] pick(input logic [REQ_W-1:0] d,
                                        input logic [1:0] sz,
                                        input logic [1:0] off);
        int unsigned sh;
        sh = (size_bytes(sz) - 1 - int'(off)) * 8;
        return 8'(d >> sh);
    endfunction

    logic [7:0] b_first;
    logic [7:0] b_second;
    logic [1:0] lane_used;

    always_comb begin
        b_first  = pick(wdata, size, piece.offs);
        b_second = pick(wdata, size, piece.offs + 2'd1);
        if (bus8) begin
            hi_used = 1'b0;
            lo_used = 1'b1;
        end else if (piece.half) begin
            hi_used = 1'b1;
            lo_used = 1'b1;
        end else begin
            hi_used = ~cyc_addr0;
            lo_used = cyc_addr0;
        end
        lane_used = {hi_used, lo_used};

        dout = '0;
        if (drive && write) begin
            if (piece.half && !bus8) begin
                dout = {b_first, b_second};
            end else if (hi_used) begin
                dout = {b_first, 8'h00};
            end else begin
                dout = {8'h00, b_first};
            end
        end
    end

    logic [LANES-1:0] we_lane_n;
    logic [LANES-1:0] be_lane_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            we_lane_n[g] = ~(active && write && !single_strobe && lane_used[g]);
            be_lane_n[g] = ~(active && single_strobe && !bus8 && lane_used[g]);
        end
    end

    always_comb begin
        rd_n    = ~(active && !write);
        we_n    = ~(active && write && single_strobe);
        we_hi_n = we_lane_n[1];
        we_lo_n = we_lane_n[0];
        be_hi_n = be_lane_n[1];
        be_lo_n = be_lane_n[0];
    end

    p_narrow_lo_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus8 |-> (we_hi_n && be_hi_n && be_lo_n));

    p_one_write_scheme_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && (!we_hi_n || !we_lo_n)));

    p_read_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (we_n && we_hi_n && we_lo_n));
endmodule

// File: rtl/ebus_gather.sv
module ebus_gather
    import ebus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    input  logic             bus8,
    input  logic [1:0]       size,
    input  logic             cyc_addr0,
    input  piece_t           piece,
    input  logic [EXT_W-1:0] din,
    output logic [REQ_W-1:0] rdata
);
    logic [REQ_W-1:0] acc_q;
    logic [REQ_W-1:0] acc_d;
    int unsigned      pos_a;
    int unsigned      pos_b;
    logic [7:0]       byte_a;
    logic [7:0]       byte_b;
    logic             take_b;

    always_comb begin
        pos_a  = size_bytes(size) - 1 - int'(piece.offs);
        pos_b  = (pos_a == 0) ? 0 : pos_a - 1;
        take_b = piece.half && !bus8;
        if (bus8) begin
            byte_a = din[7:0];
        end else if (piece.half) begin
            byte_a = din[15:8];
        end else begin
            byte_a = cyc_addr0 ? din[7:0] : din[15:8];
        end
        byte_b = din[7:0];

        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (capture) begin
            for (int k = 0; k < REQ_BYTES; k++) begin
                if (k == int'(pos_a)) acc_d[8*k +: 8] = byte_a;
                if (take_b && k == int'(pos_b)) acc_d[8*k +: 8] = byte_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign rdata = acc_q;

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rdata == '0));
endmodule

// File: rtl/ebus_splitter.sv
module ebus_splitter
    import ebus_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              cfg_bus8,
    input  logic              cfg_single_strobe,
    input  logic              cfg_page_rd,
    input  logic              cfg_page_wr,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [15:0]       ext_dout,
    input  logic [15:0]       ext_din,
    output logic              ext_rd_n,
    output logic              ext_we_n,
    output logic              ext_we_hi_n,
    output logic              ext_we_lo_n,
    output logic              ext_be_hi_n,
    output logic              ext_be_lo_n,
    output logic              ext_page
);
    bus_state_e        st_q;
    bus_state_e        st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  idx_d;
    logic              r_write;
    logic [1:0]        r_size;
    logic [ADDR_W-1:0] r_addr;
    logic [REQ_W-1:0]  r_wdata;
    logic              r_bus8;
    logic              r_single;
    logic              r_pg_rd;
    logic              r_pg_wr;

    logic [CNT_W-1:0]  count;
    piece_t            piece;
    logic              accept;
    logic              last_piece;

    assign accept     = (st_q == ST_IDLE) && req_valid;
    assign last_piece = ({1'b0, idx_q} == count - CNT_W'(1));

    ebus_plan u_plan (
        .size     (r_size),
        .addr_odd (r_addr[0]),
        .bus8     (r_bus8),
        .idx      (idx_q),
        .count    (count),
        .piece    (piece)
    );

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d  = ST_ADDR;
                    idx_d = '0;
                end
            end
            ST_ADDR: st_d = ST_STRB;
            ST_STRB: begin
                if (last_piece) begin
                    st_d = ST_FINISH;
                end else begin
                    st_d  = ST_ADDR;
                    idx_d = idx_q + IDX_W'(1);
                end
            end
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            idx_q    <= '0;
            r_write  <= 1'b0;
            r_size   <= SZ_BYTE;
            r_addr   <= '0;
            r_wdata  <= '0;
            r_bus8   <= 1'b0;
            r_single <= 1'b0;
            r_pg_rd  <= 1'b0;
            r_pg_wr  <= 1'b0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            if (accept) begin
                r_write  <= req_write;
                r_size   <= req_size;
                r_addr   <= req_addr;
                r_wdata  <= req_wdata;
                r_bus8   <= cfg_bus8;
                r_single <= cfg_single_strobe;
                r_pg_rd  <= cfg_page_rd;
                r_pg_wr  <= cfg_page_wr;
            end
        end
    end

    logic in_cycle;
    logic strobing;
    logic hi_used;
    logic lo_used;

    always_comb begin
        in_cycle = (st_q == ST_ADDR) || (st_q == ST_STRB);
        strobing = (st_q == ST_STRB);
        busy     = (st_q != ST_IDLE);
        done     = (st_q == ST_FINISH);
        ext_addr = r_addr + ADDR_W'(piece.offs);
        ext_page = in_cycle && (idx_q != '0) && (r_size != SZ_BYTE)
                   && (r_size != SZ_RSVD) && (r_write ? r_pg_wr : r_pg_rd);
    end

    ebus_lanes u_lanes (
        .clk           (clk),
        .rst_n         (rst_n),
        .active        (strobing),
        .drive         (in_cycle),
        .write         (r_write),
        .bus8          (r_bus8),
        .single_strobe (r_single),
        .size          (r_size),
        .cyc_addr0     (ext_addr[0]),
        .piece         (piece),
        .wdata         (r_wdata),
        .dout          (ext_dout),
        .hi_used       (hi_used),
        .lo_used       (lo_used),
        .rd_n          (ext_rd_n),
        .we_n          (ext_we_n),
        .we_hi_n       (ext_we_hi_n),
        .we_lo_n       (ext_we_lo_n),
        .be_hi_n       (ext_be_hi_n),
        .be_lo_n       (ext_be_lo_n)
    );

    ebus_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (strobing && !r_write),
        .bus8      (r_bus8),
        .size      (r_size),
        .cyc_addr0 (ext_addr[0]),
        .piece     (piece),
        .din       (ext_din),
        .rdata     (rdata)
    );

    p_strobes_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_STRB) |-> (ext_rd_n && ext_we_n && ext_we_hi_n && ext_we_lo_n
                               && ext_be_hi_n && ext_be_lo_n));

    p_addr_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STRB) |-> $stable(ext_addr));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(r_addr));

    p_first_not_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_STRB) && (idx_q == '0)) |-> !ext_page);

    p_half_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_STRB) && hi_used && lo_used) |-> !ext_addr[0]);
endmodule

// File: tb/tb_ebus_splitter.sv
module tb_ebus_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_bus8 = 1'b0;
    logic        cfg_single_strobe = 1'b0;
    logic        cfg_page_rd = 1'b0;
    logic        cfg_page_wr = 1'b0;
    logic        busy, done;
    logic [31:0] rdata;
    logic [23:0] ext_addr;
    logic [15:0] ext_dout;
    logic [15:0] ext_din;
    logic        ext_rd_n, ext_we_n, ext_we_hi_n, ext_we_lo_n, ext_be_hi_n, ext_be_lo_n, ext_page;

    always #5 clk = ~clk;

    ebus_splitter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_bus8(cfg_bus8), .cfg_single_strobe(cfg_single_strobe),
        .cfg_page_rd(cfg_page_rd), .cfg_page_wr(cfg_page_wr),
        .busy(busy), .done(done), .rdata(rdata), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_din(ext_din), .ext_rd_n(ext_rd_n),
        .ext_we_n(ext_we_n), .ext_we_hi_n(ext_we_hi_n), .ext_we_lo_n(ext_we_lo_n),
        .ext_be_hi_n(ext_be_hi_n), .ext_be_lo_n(ext_be_lo_n), .ext_page(ext_page)
    );

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [256];
    bit          mem_fill = 1'b1;
    logic [23:0] lg_addr [8];
    logic [15:0] lg_dout [8];
    logic [5:0]  lg_str  [8];
    logic        lg_page [8];
    int          lg_n = 0;

    always_comb begin
        if (cfg_bus8) ext_din = {8'h00, mem[ext_addr[7:0]]};
        else          ext_din = {mem[{ext_addr[7:1], 1'b0}], mem[{ext_addr[7:1], 1'b1}]};
    end

    always @(negedge clk) begin
        logic wh, wl;
        cycles = cycles + 1;
        if (mem_fill) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
            mem_fill = 1'b0;
        end else if (!(ext_rd_n && ext_we_n && ext_we_hi_n && ext_we_lo_n
                       && ext_be_hi_n && ext_be_lo_n)) begin
            if (lg_n < 8) begin
                lg_addr[lg_n] = ext_addr;
                lg_dout[lg_n] = ext_dout;
                lg_str[lg_n]  = {ext_rd_n, ext_we_n, ext_we_hi_n, ext_we_lo_n, ext_be_hi_n, ext_be_lo_n};
                lg_page[lg_n] = ext_page;
            end
            lg_n = lg_n + 1;
            if (cfg_single_strobe) begin
                wh = !ext_we_n && !ext_be_hi_n;
                wl = !ext_we_n && (cfg_bus8 || !ext_be_lo_n);
            end else begin
                wh = !ext_we_hi_n;
                wl = !ext_we_lo_n;
            end
            if (cfg_bus8) begin
                if (wl) mem[ext_addr[7:0]] = ext_dout[7:0];
            end else begin
                if (wh) mem[{ext_addr[7:1], 1'b0}] = ext_dout[15:8];
                if (wl) mem[{ext_addr[7:1], 1'b1}] = ext_dout[7:0];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
    endfunction

    function automatic string cat_tag(input logic [1:0] sz, input logic a0, input bit b8);
        if (b8) return "R6";
        if (sz == 2'd1) return a0 ? "R3" : "R2";
        if (sz == 2'd2) return a0 ? "R5" : "R4";
        return "R1";
    endfunction

    task automatic run(input bit w, input logic [1:0] sz, input logic [23:0] a,
                       input logic [31:0] wd, input bit b8, input bit md,
                       input bit pr, input bit pw, input bit intrude);
        int          n, np, cnt;
        logic [1:0]  offs [4];
        bit          half [4];
        logic [31:0] exp_rd;
        logic [7:0]  bt;
        string       tg;
        int          nb;
        @(negedge clk);
        nb = nbytes(sz);
        tg = cat_tag(sz, a[0], b8);
        if (b8) begin
            np = nb;
            for (int i = 0; i < 4; i++) begin offs[i] = 2'(i); half[i] = 1'b0; end
        end else if (sz == 2'd1 && !a[0]) begin
            np = 1; offs[0] = 2'd0; half[0] = 1'b1;
        end else if (sz == 2'd1) begin
            np = 2; offs[0] = 2'd0; offs[1] = 2'd1; half[0] = 1'b0; half[1] = 1'b0;
        end else if (sz == 2'd2 && !a[0]) begin
            np = 2; offs[0] = 2'd0; offs[1] = 2'd2; half[0] = 1'b1; half[1] = 1'b1;
        end else if (sz == 2'd2) begin
            np = 3; offs[0] = 2'd0; offs[1] = 2'd1; offs[2] = 2'd3;
            half[0] = 1'b0; half[1] = 1'b1; half[2] = 1'b0;
        end else begin
            np = 1; offs[0] = 2'd0; half[0] = 1'b0;
        end
        exp_rd = '0;
        for (int j = 0; j < nb; j++) exp_rd[8*(nb-1-j) +: 8] = mem[8'(a + 24'(j))];
        cfg_bus8 = b8; cfg_single_strobe = md; cfg_page_rd = pr; cfg_page_wr = pw;
        req_write = w; req_size = sz; req_addr = a; req_wdata = wd;
        lg_n = 0;
        req_valid = 1'b1;
        cnt = 0;
        n = 0;
        while (n == 0) begin
            @(negedge clk);
            cnt = cnt + 1;
            if (cnt == 1) req_valid = 1'b0;
            if (intrude && cnt == 3) begin
                req_valid = 1'b1; req_addr = a ^ 24'h000055; req_size = 2'd2; req_write = ~w;
            end
            if (intrude && cnt == 4) req_valid = 1'b0;
            if (done) n = 1;
            if (cnt > 40) n = 2;
        end
        check(n == 1 && cnt == 2 * np + 1, "R10", "done latency", 32'(cnt), 32'(2 * np + 1));
        if (!w) check(rdata == exp_rd, (sz == 2'd3) ? "R9" : tg, "read data", rdata, exp_rd);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(lg_n == np, intrude ? "R9" : tg, "cycle count", 32'(lg_n), 32'(np));
        for (int i = 0; i < np && i < lg_n && i < 8; i++) begin
            logic hu, lu, ok;
            logic [23:0] ea;
            logic [5:0]  es;
            logic [15:0] msk, ed;
            ea = a + 24'(offs[i]);
            if (b8) begin hu = 1'b0; lu = 1'b1; end
            else if (half[i]) begin hu = 1'b1; lu = 1'b1; end
            else begin hu = ~ea[0]; lu = ea[0]; end
            if (md) es = {w, ~w, 1'b1, 1'b1, ~(hu && !b8), ~(lu && !b8)};
            else    es = {w, 1'b1, ~(w && hu), ~(w && lu), 1'b1, 1'b1};
            check(lg_addr[i] == ea, tg, "cycle address", 32'(lg_addr[i]), 32'(ea));
            check(lg_str[i] == es, "R7", "strobe pattern", 32'(lg_str[i]), 32'(es));
            ok = (i > 0) && (sz == 2'd1 || sz == 2'd2) && (w ? pw : pr);
            check(lg_page[i] == ok, "R8", "page flag", 32'(lg_page[i]), 32'(ok));
            if (w) begin
                msk = {{8{hu}}, {8{lu}}};
                ed  = '0;
                bt  = 8'(wd >> (8 * (nb - 1 - int'(offs[i]))));
                if (half[i] && !b8) ed = {bt, 8'(wd >> (8 * (nb - 2 - int'(offs[i]))))};
                else if (hu) ed = {bt, 8'h00};
                else ed = {8'h00, bt};
                check((lg_dout[i] & msk) == ed, hu && !lu ? "R1" : tg, "lane data",
                      32'(lg_dout[i] & msk), 32'(ed));
            end
        end
        if (w) begin
            logic [31:0] got, expw;
            got = '0;
            expw = wd & ((nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1));
            for (int j = 0; j < nb; j++) got[8*(nb-1-j) +: 8] = mem[8'(a + 24'(j))];
            check(got == expw, "R2", "big-endian memory image", got, expw);
        end
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        check(ext_rd_n && ext_we_n && ext_we_hi_n && ext_we_lo_n && ext_be_hi_n && ext_be_lo_n,
              "R11", "strobes in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !ext_page && ext_addr == 24'd0, "R11", "idle after reset",
              {28'd0, busy, done, ext_page, |ext_addr}, 32'd0);
        run(1'b1, 2'd0, 24'h000010, 32'h0000_00A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run(1'b1, 2'd0, 24'h000011, 32'h0000_005C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        run(1'b0, 2'd1, 24'h000020, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        run(1'b1, 2'd1, 24'h000023, 32'h0000_BEEF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        run(1'b1, 2'd2, 24'h000040, 32'h1122_3344, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        run(1'b0, 2'd2, 24'h000041, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(1'b1, 2'd2, 24'h000043, 32'hCAFE_F00D, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        run(1'b1, 2'd2, 24'h0000FF, 32'hA1B2_C3D4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run(1'b0, 2'd1, 24'h000033, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run(1'b0, 2'd3, 24'h000052, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        run(1'b1, 2'd2, 24'h000061, 32'h0BAD_CAFE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        run(1'b0, 2'd1, 24'h000071, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 250; k++) begin
            logic [31:0] r;
            r = $urandom;
            run(r[0], 2'($urandom_range(0, 2)), 24'($urandom), $urandom,
                r[1], r[2], r[3], r[4], r[5] && r[6]);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!finished) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule